// File: doc/BRIEF.md
# Descriptor Ring Prefetch Cache

This block sits between a network controller's descriptor ring in memory and the engine that consumes descriptors. It holds the ring's base address, length and head, and it watches the tail index that software advances. When asked, it reads a burst of descriptors from memory into a small local cache. It then offers them one at a time, in ring order, to a consumer port. The consumer reports each descriptor it finishes, and that descriptor becomes used.

On request, the block writes the used descriptors back to memory in bursts and moves the head index forward once each burst completes. A burst can be trimmed to a multiple set by an alignment mask. It can also be cut short at the end of the ring, in which case a follow-up burst is queued. Memory traffic runs over two request/accept/done handshakes, one for reads and one for writes. Each trigger waits for a programmable number of cycles before its request goes out, which lets several triggers merge into one burst. The cache tracks ring indices. The descriptor contents stay in memory.

Top module: `desc_ring_cache`

## Requirements
- R1: The ring holds `cfg_len_bytes >> 4` descriptors, each 16 bytes. The memory address of ring index i is `cfg_base + 16*i`, on both the read and the write request.
- R2: A fetch reads `tail - fptr` descriptors when the tail is at or above the fetch pointer. Otherwise it reads `ring_len - fptr`, so a fetch never crosses the end of the ring.
- R3: The fetch count is capped at the free cache slots, which are DEPTH minus the used entries minus the unused entries. A count of zero raises no read request.
- R4: At most one fetch is in flight. A fetch trigger during the request or the transfer is ignored, and a trigger during the delay count does not restart the count.
- R5: When a fetch completes, its descriptors join the cache in ring order and the fetch pointer advances by the count, wrapping to 0 at the ring length. `desc_valid`/`desc_idx` show the oldest unconsumed index, and `desc_take` consumes it.
- R6: The writeback count starts as the number of used entries. If head plus count reaches or passes the ring length, the count becomes `ring_len - head` and a follow-up burst is queued. That burst is issued after the first completes.
- R7: When there is no clip and the alignment mask is nonzero, the writeback count is ANDed with the inverse of the mask. A count of zero raises no write request and leaves the head unchanged.
- R8: A writeback trigger that arrives while a writeback is in flight only records state. If its mask is below the current mask, the new mask is kept and a follow-up burst is queued.
- R9: When a writeback completes, `ring_head` advances by the count modulo the ring length. `wb_cmpl` is high for exactly one cycle, with the new head already visible, and a fetch attempt follows.
- R10: A `cfg_we` while used entries, a fetch in flight or a writeback in flight exist is ignored and sets the sticky `cfg_err`. Otherwise base, length and head are loaded, the cache is emptied and the fetch pointer returns to 0.
- R11: A trigger sampled at clock edge 0, with no delay count already running, raises its request after edge `trig_dly + 1`.
- R12: A read or write request stays high with a stable address and count until its accept is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load base, length and head (one-cycle pulse) |
| cfg_base | input | ADDR_W | Ring base address |
| cfg_len_bytes | input | IDX_W+5 | Ring length in bytes |
| cfg_head | input | IDX_W | Head index to load |
| ring_tail | input | IDX_W | Tail index written by software |
| trig_dly | input | DLY_W | Cycles between a trigger and its request |
| fetch_trig | input | 1 | Request a descriptor fetch |
| wb_trig | input | 1 | Request a writeback |
| wb_mask | input | IDX_W | Alignment mask for the writeback count |
| rd_req | output | 1 | Read burst request |
| rd_addr | output | ADDR_W | Read burst address |
| rd_cnt | output | $clog2(DEPTH)+1 | Descriptors in the read burst |
| rd_ack | input | 1 | Read request accepted |
| rd_done | input | 1 | Read burst finished (one-cycle pulse) |
| wr_req | output | 1 | Write burst request |
| wr_addr | output | ADDR_W | Write burst address |
| wr_cnt | output | $clog2(DEPTH)+1 | Descriptors in the write burst |
| wr_ack | input | 1 | Write request accepted |
| wr_done | input | 1 | Write burst finished (one-cycle pulse) |
| desc_valid | output | 1 | An unconsumed descriptor is available |
| desc_idx | output | IDX_W | Ring index of that descriptor |
| desc_take | input | 1 | Consume the offered descriptor |
| ring_head | output | IDX_W | Current head index |
| wb_cmpl | output | 1 | One-cycle pulse when a writeback completes |
| cfg_err | output | 1 | Sticky: configuration changed while busy |

## Verification
Fetches run with the tail ahead of the fetch pointer, with the tail behind it (which clips at the ring end), and with the cache nearly full and then completely full. Together these separate the tail limit, the ring-end limit and the free-slot limit, and they confirm that a zero count stays silent. Writebacks run with a zero mask, with a mask that trims the count and with a mask that trims it to nothing. A used run that crosses the ring end shows the clip and its follow-up burst, and a smaller mask given mid-flight shows the deferred follow-up. Retriggers during the delay and during a held transfer, together with a configuration write during a held writeback and another when idle, cover the single-flight rule and the flush-or-error choice.

// File: rtl/ringc_pkg.sv
package ringc_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_REQ  = 2'd1,
    CH_BUSY = 2'd2
  } chan_st_e;

  // Descriptors to read: up to the tail, or up to the ring end if the
  // tail has wrapped; then capped by the free cache slots.
  function automatic logic [31:0] fetch_span(input logic [31:0] tail,
                                             input logic [31:0] fptr,
                                             input logic [31:0] len,
                                             input logic [31:0] free);
    logic [31:0] s;
    s = (tail >= fptr) ? (tail - fptr) : (len - fptr);
    return (s < free) ? s : free;
  endfunction

  // True when writing every used entry would reach the ring end.
  function automatic logic wb_hits_end(input logic [31:0] used,
                                       input logic [31:0] head,
                                       input logic [31:0] len);
    return (used + head) >= len;
  endfunction

  // Descriptors to write back, after the ring-end clip or the mask trim.
  function automatic logic [31:0] wb_span(input logic [31:0] used,
                                          input logic [31:0] head,
                                          input logic [31:0] len,
                                          input logic [31:0] mask);
    if (wb_hits_end(used, head, len)) return len - head;
    if (mask != 32'd0) return used & ~mask;
    return used;
  endfunction

endpackage

// File: rtl/ringc_delay.sv
module ringc_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DLY_W-1:0] dly,
  output logic             pending,
  output logic             fire
);
  logic [DLY_W-1:0] cnt;

  assign fire = pending && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (pending) begin
      if (cnt == '0) pending <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= dly;
    end
  end

  // R11 / R4: a running count is neither dropped nor restarted before it fires
  a_r4_count_not_restarted: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !fire |=> pending && (cnt == $past(cnt) - 1'b1));
  a_r11_fire_ends_count: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pending);

endmodule

// File: rtl/ringc_queue.sv
module ringc_queue #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int OCC_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [OCC_W-1:0] push_n,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             take,
  input  logic [OCC_W-1:0] retire_n,
  output logic [OCC_W-1:0] used_n,
  output logic [OCC_W-1:0] unused_n,
  output logic [OCC_W-1:0] free_n,
  output logic             avail,
  output logic [IDX_W-1:0] front_idx
);
  // One circular buffer: [wb_p, use_p) used, [use_p, fill_p) unused.
  logic [OCC_W-1:0] wb_p, use_p, fill_p;
  logic [IDX_W-1:0] slot [DEPTH];
  logic             take_ok;

  assign used_n    = use_p - wb_p;
  assign unused_n  = fill_p - use_p;
  assign free_n    = OCC_W'(DEPTH) - (fill_p - wb_p);
  assign avail     = (unused_n != '0);
  assign front_idx = slot[use_p[PTR_W-1:0]];
  assign take_ok   = take && avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_p   <= '0;
      use_p  <= '0;
      fill_p <= '0;
    end else if (flush) begin
      wb_p   <= '0;
      use_p  <= '0;
      fill_p <= '0;
    end else begin
      fill_p <= fill_p + push_n;
      use_p  <= use_p + OCC_W'(take_ok);
      wb_p   <= wb_p + retire_n;
    end
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic [PTR_W-1:0] ofs;
    assign ofs = PTR_W'(j) - fill_p[PTR_W-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[j] <= '0;
      else if (!flush && (OCC_W'(ofs) < push_n))
        slot[j] <= push_idx + IDX_W'(ofs);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_p - wb_p) <= OCC_W'(DEPTH));
  a_r6_retire_within_used: assert property (@(posedge clk) disable iff (!rst_n)
    retire_n <= used_n);
  a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
    push_n <= free_n);

endmodule

// File: rtl/ringc_fetch_ctl.sv
module ringc_fetch_ctl
  import ringc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 8,
  parameter int DLY_W  = 8,
  localparam int CNT_W = IDX_W + 1,
  localparam int OCC_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DLY_W-1:0]  dly,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  ring_len,
  input  logic [IDX_W-1:0]  tail,
  input  logic [OCC_W-1:0]  free_n,
  input  logic              flush,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [OCC_W-1:0]  rd_cnt,
  input  logic              rd_ack,
  input  logic              rd_done,
  output logic [OCC_W-1:0]  push_n,
  output logic [IDX_W-1:0]  push_idx,
  output logic              inflight
);
  chan_st_e         st;
  logic [IDX_W-1:0] fptr;
  logic             dly_pending, dly_fire, fetch_end;
  logic [OCC_W-1:0] span;
  logic [CNT_W-1:0] fptr_nxt;

  ringc_delay #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (trig && (st == CH_IDLE)),
    .dly     (dly),
    .pending (dly_pending),
    .fire    (dly_fire)
  );

  assign span      = OCC_W'(fetch_span(32'(tail), 32'(fptr), 32'(ring_len), 32'(free_n)));
  assign fetch_end = (st == CH_BUSY) && rd_done;
  assign fptr_nxt  = {1'b0, fptr} + CNT_W'(rd_cnt);
  assign rd_req    = (st == CH_REQ);
  assign inflight  = (st != CH_IDLE);
  assign push_n    = fetch_end ? rd_cnt : '0;
  assign push_idx  = fptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CH_IDLE;
      fptr    <= '0;
      rd_addr <= '0;
      rd_cnt  <= '0;
    end else begin
      if (flush) fptr <= '0;
      unique case (st)
        CH_IDLE: if (dly_fire && span != '0) begin
          st      <= CH_REQ;
          rd_cnt  <= span;
          rd_addr <= base + ADDR_W'({fptr, 4'b0000});
        end
        CH_REQ:  if (rd_ack) st <= CH_BUSY;
        CH_BUSY: if (rd_done) begin
          st   <= CH_IDLE;
          fptr <= (fptr_nxt >= ring_len) ? '0 : fptr_nxt[IDX_W-1:0];
        end
        default: st <= CH_IDLE;
      endcase
    end
  end

  a_r12_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_cnt));
  a_r2_no_ring_cross: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> ({1'b0, fptr} + CNT_W'(rd_cnt)) <= ring_len);
  a_r3_rd_fits_free: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_cnt != '0) && (rd_cnt <= free_n));
  a_r4_no_delay_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    inflight |-> !dly_pending);

endmodule

// File: rtl/ringc_wb_ctl.sv
module ringc_wb_ctl
  import ringc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 8,
  parameter int DLY_W  = 8,
  localparam int CNT_W = IDX_W + 1,
  localparam int OCC_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [IDX_W-1:0]  mask,
  input  logic [DLY_W-1:0]  dly,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  ring_len,
  input  logic              head_load,
  input  logic [IDX_W-1:0]  head_val,
  input  logic [OCC_W-1:0]  used_n,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [OCC_W-1:0]  wr_cnt,
  input  logic              wr_ack,
  input  logic              wr_done,
  output logic [OCC_W-1:0]  retire_n,
  output logic [IDX_W-1:0]  head,
  output logic              cmpl,
  output logic              inflight
);
  chan_st_e         st;
  logic [IDX_W-1:0] cur_mask;
  logic             more;
  logic             dly_pending, dly_fire, wb_end, clip, launch;
  logic [OCC_W-1:0] span;
  logic [CNT_W-1:0] head_nxt;

  assign wb_end   = (st == CH_BUSY) && wr_done;

  ringc_delay #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   ((trig && (st == CH_IDLE)) || (wb_end && more)),
    .dly     (dly),
    .pending (dly_pending),
    .fire    (dly_fire)
  );

  assign span     = OCC_W'(wb_span(32'(used_n), 32'(head), 32'(ring_len), 32'(cur_mask)));
  assign clip     = wb_hits_end(32'(used_n), 32'(head), 32'(ring_len));
  assign launch   = (st == CH_IDLE) && dly_fire && (span != '0);
  assign retire_n = launch ? span : '0;
  assign head_nxt = {1'b0, head} + CNT_W'(wr_cnt);
  assign wr_req   = (st == CH_REQ);
  assign inflight = (st != CH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= CH_IDLE;
      head     <= '0;
      cur_mask <= '0;
      more     <= 1'b0;
      wr_addr  <= '0;
      wr_cnt   <= '0;
      cmpl     <= 1'b0;
    end else begin
      cmpl <= wb_end;
      if (head_load) head <= head_val;
      unique case (st)
        CH_IDLE: begin
          if (trig) cur_mask <= mask;
          if (dly_fire && clip) more <= 1'b1;
          if (launch) begin
            st      <= CH_REQ;
            wr_cnt  <= span;
            wr_addr <= base + ADDR_W'({head, 4'b0000});
          end
        end
        CH_REQ, CH_BUSY: begin
          if (trig && (mask < cur_mask)) begin
            cur_mask <= mask;
            more     <= 1'b1;
          end
          if (st == CH_REQ && wr_ack) st <= CH_BUSY;
          if (wb_end) begin
            st   <= CH_IDLE;
            head <= (head_nxt >= ring_len) ? IDX_W'(head_nxt - ring_len)
                                           : head_nxt[IDX_W-1:0];
            if (!(trig && (mask < cur_mask))) more <= 1'b0;
          end
        end
        default: st <= CH_IDLE;
      endcase
    end
  end

  a_r12_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_cnt));
  a_r6_no_ring_cross: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ({1'b0, head} + CNT_W'(wr_cnt)) <= ring_len);
  a_r7_no_empty_burst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> wr_cnt != '0);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> !cmpl);
  a_r9_head_stable_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> $stable(head));

endmodule

// File: rtl/desc_ring_cache.sv
module desc_ring_cache #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 8,
  parameter int DLY_W  = 8,
  localparam int CNT_W  = IDX_W + 1,
  localparam int LENB_W = CNT_W + 4,
  localparam int OCC_W  = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LENB_W-1:0] cfg_len_bytes,
  input  logic [IDX_W-1:0]  cfg_head,
  input  logic [IDX_W-1:0]  ring_tail,
  input  logic [DLY_W-1:0]  trig_dly,
  input  logic              fetch_trig,
  input  logic              wb_trig,
  input  logic [IDX_W-1:0]  wb_mask,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [OCC_W-1:0]  rd_cnt,
  input  logic              rd_ack,
  input  logic              rd_done,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [OCC_W-1:0]  wr_cnt,
  input  logic              wr_ack,
  input  logic              wr_done,
  output logic              desc_valid,
  output logic [IDX_W-1:0]  desc_idx,
  input  logic              desc_take,
  output logic [IDX_W-1:0]  ring_head,
  output logic              wb_cmpl,
  output logic              cfg_err
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  len_q;
  logic [OCC_W-1:0]  used_n, unused_n, free_n, push_n, retire_n;
  logic [IDX_W-1:0]  push_idx;
  logic              f_inflight, w_inflight, busy_any, cfg_ok;

  assign busy_any = (used_n != '0) || f_inflight || w_inflight;
  assign cfg_ok   = cfg_we && !busy_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      len_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_ok) begin
        base_q <= cfg_base;
        len_q  <= cfg_len_bytes[LENB_W-1:4];
      end
      if (cfg_we && busy_any) cfg_err <= 1'b1;
    end
  end

  ringc_queue #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (cfg_ok),
    .push_n    (push_n),
    .push_idx  (push_idx),
    .take      (desc_take),
    .retire_n  (retire_n),
    .used_n    (used_n),
    .unused_n  (unused_n),
    .free_n    (free_n),
    .avail     (desc_valid),
    .front_idx (desc_idx)
  );

  ringc_fetch_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (fetch_trig || wb_cmpl),
    .dly      (trig_dly),
    .base     (base_q),
    .ring_len (len_q),
    .tail     (ring_tail),
    .free_n   (free_n),
    .flush    (cfg_ok),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_cnt   (rd_cnt),
    .rd_ack   (rd_ack),
    .rd_done  (rd_done),
    .push_n   (push_n),
    .push_idx (push_idx),
    .inflight (f_inflight)
  );

  ringc_wb_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (wb_trig),
    .mask      (wb_mask),
    .dly       (trig_dly),
    .base      (base_q),
    .ring_len  (len_q),
    .head_load (cfg_ok),
    .head_val  (cfg_head),
    .used_n    (used_n),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_cnt    (wr_cnt),
    .wr_ack    (wr_ack),
    .wr_done   (wr_done),
    .retire_n  (retire_n),
    .head      (ring_head),
    .cmpl      (wb_cmpl),
    .inflight  (w_inflight)
  );

  a_r10_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && busy_any |=> cfg_err);
  a_r10_idle_write_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> (used_n == '0) && (unused_n == '0) && $stable(cfg_err));
  a_r4_one_request_each: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !(f_inflight && push_n != '0));

endmodule

// File: tb/desc_ring_cache_test.sv
module desc_ring_cache_test;
  localparam int ADDR_W = 32, IDX_W = 8, DEPTH = 8, DLY_W = 8;
  localparam int OCC_W = $clog2(DEPTH) + 1;
  localparam int DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, fetch_trig = 0, wb_trig = 0, desc_take = 0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [IDX_W+4:0]  cfg_len_bytes = '0;
  logic [IDX_W-1:0]  cfg_head = '0, ring_tail = '0, wb_mask = '0;
  logic [DLY_W-1:0]  trig_dly = DLY_W'(DLY);
  logic rd_ack = 0, rd_done = 0, wr_ack = 0, wr_done = 0;
  logic rd_req, wr_req, desc_valid, wb_cmpl, cfg_err;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [OCC_W-1:0]  rd_cnt, wr_cnt;
  logic [IDX_W-1:0]  desc_idx, ring_head;

  desc_ring_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_len_bytes(cfg_len_bytes), .cfg_head(cfg_head), .ring_tail(ring_tail),
    .trig_dly(trig_dly), .fetch_trig(fetch_trig), .wb_trig(wb_trig), .wb_mask(wb_mask),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_ack(rd_ack), .rd_done(rd_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_cnt(wr_cnt), .wr_ack(wr_ack), .wr_done(wr_done),
    .desc_valid(desc_valid), .desc_idx(desc_idx), .desc_take(desc_take),
    .ring_head(ring_head), .wb_cmpl(wb_cmpl), .cfg_err(cfg_err));

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, errors = 0;
  int rd_reqs = 0, rd_dones = 0, wr_reqs = 0, wr_dones = 0;
  int cmpl_cnt = 0, cmpl_multi = 0;
  int ack_lag = 0, hold_bad = 0;
  bit rd_hold = 0, wr_hold = 0, finished = 0;
  logic [ADDR_W-1:0] rd_alog [16], wr_alog [16];
  int rd_clog [16], wr_clog [16];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory model, read side
  initial forever begin
    @(negedge clk);
    if (rd_req) begin
      logic [ADDR_W-1:0] a0; logic [OCC_W-1:0] c0;
      a0 = rd_addr; c0 = rd_cnt;
      repeat (ack_lag) begin
        @(negedge clk);
        if (!rd_req || rd_addr != a0 || rd_cnt != c0) hold_bad++;
      end
      rd_ack = 1; rd_alog[rd_reqs % 16] = rd_addr; rd_clog[rd_reqs % 16] = int'(rd_cnt);
      rd_reqs++;
      @(negedge clk); rd_ack = 0;
      while (rd_hold) @(negedge clk);
      repeat (2) @(negedge clk);
      rd_done = 1; @(negedge clk); rd_done = 0; rd_dones++;
    end
  end

  // memory model, write side
  initial forever begin
    @(negedge clk);
    if (wr_req) begin
      logic [ADDR_W-1:0] a0; logic [OCC_W-1:0] c0;
      a0 = wr_addr; c0 = wr_cnt;
      repeat (ack_lag) begin
        @(negedge clk);
        if (!wr_req || wr_addr != a0 || wr_cnt != c0) hold_bad++;
      end
      wr_ack = 1; wr_alog[wr_reqs % 16] = wr_addr; wr_clog[wr_reqs % 16] = int'(wr_cnt);
      wr_reqs++;
      @(negedge clk); wr_ack = 0;
      while (wr_hold) @(negedge clk);
      repeat (2) @(negedge clk);
      wr_done = 1; @(negedge clk); wr_done = 0; wr_dones++;
    end
  end

  // completion pulse monitor
  initial begin
    bit prev = 0;
    forever begin
      @(posedge clk); #1;
      if (wb_cmpl) begin cmpl_cnt++; if (prev) cmpl_multi++; end
      prev = wb_cmpl;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hang expected=finish");
    summary();
  end

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic pulse_fetch(); @(negedge clk) fetch_trig = 1; @(negedge clk) fetch_trig = 0; endtask

  task automatic pulse_wb(input logic [IDX_W-1:0] m);
    @(negedge clk) begin wb_trig = 1; wb_mask = m; end
    @(negedge clk) wb_trig = 0;
  endtask

  task automatic configure(input logic [ADDR_W-1:0] b, input int ndesc, input int h);
    @(negedge clk) begin
      cfg_we = 1; cfg_base = b; cfg_len_bytes = (IDX_W+5)'(ndesc * 16); cfg_head = IDX_W'(h);
    end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic wait_rd(input int n);
    for (int i = 0; i < 400 && rd_dones < n; i++) @(negedge clk);
    idle(12);
  endtask

  task automatic wait_wr(input int n);
    for (int i = 0; i < 400 && wr_dones < n; i++) @(negedge clk);
    idle(12);
  endtask

  task automatic consume(input string req, input int first, input int n, input int len);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk({req, " desc_valid"}, desc_valid, 1);
      chk({req, " desc_idx"}, desc_idx, (first + k) % len);
      desc_take = 1;
      @(negedge clk) desc_take = 0;
    end
  endtask

  task automatic measure_fetch_latency(input string req, input bit retrig);
    int lat;
    @(negedge clk) fetch_trig = 1;
    @(negedge clk) fetch_trig = 0; lat = 1;
    if (retrig) begin
      @(negedge clk) fetch_trig = 1; lat++;
      @(negedge clk) fetch_trig = 0; lat++;
    end
    while (!rd_req && lat < 100) begin @(negedge clk); lat++; end
    chk(req, lat, DLY + 2);
  endtask

  // reset state
  task automatic t_reset();
    idle(2);
    chk("R5 reset desc_valid", desc_valid, 0);
    chk("R12 reset rd_req", rd_req, 0);
    chk("R12 reset wr_req", wr_req, 0);
    chk("R10 reset cfg_err", cfg_err, 0);
    chk("R9 reset ring_head", ring_head, 0);
  endtask

  // first fetch, consume, writeback
  task automatic t_basic();
    int r0 = rd_reqs, w0 = wr_reqs, c0 = cmpl_cnt;
    configure(32'h1000, 12, 0);
    ring_tail = 8'd5;
    measure_fetch_latency("R11 trigger to request", 0);
    wait_rd(rd_dones + 1);
    chk("R1 fetch address", rd_alog[r0 % 16], 32'h1000);
    chk("R2 fetch count tail ahead", rd_clog[r0 % 16], 5);
    consume("R5 ring order", 0, 5, 12);
    @(negedge clk); chk("R5 drained", desc_valid, 0);
    pulse_wb(8'd0);
    wait_wr(wr_dones + 1);
    chk("R6 wb count", wr_clog[w0 % 16], 5);
    chk("R1 wb address", wr_alog[w0 % 16], 32'h1000);
    chk("R9 head advanced", ring_head, 5);
    chk("R9 one completion", cmpl_cnt - c0, 1);
    chk("R9 fetch attempt with nothing to read", rd_reqs - r0, 1);
  endtask

  // ring-end limit, free-slot limit, full cache
  task automatic t_limits();
    int r0 = rd_reqs;
    ring_tail = 8'd3;
    pulse_fetch(); wait_rd(rd_dones + 1);
    chk("R2 clipped at ring end", rd_clog[r0 % 16], 7);
    chk("R1 fetch address mid ring", rd_alog[r0 % 16], 32'h1050);
    pulse_fetch(); wait_rd(rd_dones + 1);
    chk("R3 capped by free slots", rd_clog[(r0 + 1) % 16], 1);
    chk("R5 pointer wrapped to 0", rd_alog[(r0 + 1) % 16], 32'h1000);
    pulse_fetch(); idle(20);
    chk("R3 full cache no request", rd_reqs - r0, 2);
  endtask

  // mask trimming
  task automatic t_mask();
    int r0 = rd_reqs, w0 = wr_reqs;
    consume("R5 order after wrap", 5, 3, 12);
    pulse_wb(8'd1);
    wait_wr(wr_dones + 1);
    chk("R7 count trimmed by mask", wr_clog[w0 % 16], 2);
    chk("R9 head after trim", ring_head, 7);
    wait_rd(rd_dones + 1);
    chk("R9 fetch follows writeback", rd_reqs - r0, 1);
    chk("R9 follow fetch count", rd_clog[r0 % 16], 2);
    chk("R9 follow fetch address", rd_alog[r0 % 16], 32'h1010);
    pulse_wb(8'd1); idle(20);
    chk("R7 trimmed to zero no request", wr_reqs - w0, 1);
    chk("R7 head unchanged", ring_head, 7);
  endtask

  // clip at ring end with follow-up
  task automatic t_clip();
    int r0 = rd_reqs, w0 = wr_reqs, c0 = cmpl_cnt;
    consume("R5 order across end", 8, 5, 12);
    pulse_wb(8'd0);
    wait_wr(wr_dones + 2);
    chk("R6 two bursts", wr_reqs - w0, 2);
    chk("R6 clipped count", wr_clog[w0 % 16], 5);
    chk("R6 clipped address", wr_alog[w0 % 16], 32'h1070);
    chk("R6 follow-up count", wr_clog[(w0 + 1) % 16], 1);
    chk("R6 follow-up address", wr_alog[(w0 + 1) % 16], 32'h1000);
    chk("R9 head wrapped", ring_head, 1);
    chk("R9 completions", cmpl_cnt - c0, 2);
    chk("R2 no fetch at tail", rd_reqs - r0, 0);
  endtask

  // smaller mask and config write during a held writeback
  task automatic t_inflight_wb();
    int w0;
    ring_tail = 8'd5;
    pulse_fetch(); wait_rd(rd_dones + 1);
    consume("R5 order refill", 1, 3, 12);
    w0 = wr_reqs;
    wr_hold = 1;
    pulse_wb(8'd1);
    for (int i = 0; i < 100 && wr_reqs == w0; i++) @(negedge clk);
    consume("R8 consume in flight", 4, 1, 12);
    pulse_wb(8'd0);
    configure(32'h3000, 4, 0);
    idle(2);
    chk("R10 busy write flagged", cfg_err, 1);
    chk("R10 head kept", ring_head, 1);
    wr_hold = 0;
    wait_wr(wr_dones + 2);
    chk("R8 follow-up issued", wr_reqs - w0, 2);
    chk("R7 first count trimmed", wr_clog[w0 % 16], 2);
    chk("R8 follow-up count", wr_clog[(w0 + 1) % 16], 2);
    chk("R10 base kept", wr_alog[(w0 + 1) % 16], 32'h1030);
    chk("R9 head after both", ring_head, 5);
  endtask

  // legal reconfiguration, retrigger and held fetch
  task automatic t_reconfig();
    int r0;
    ack_lag = 3;
    configure(32'h2000, 4, 2);
    idle(1);
    chk("R10 head loaded", ring_head, 2);
    chk("R10 cache emptied", desc_valid, 0);
    ring_tail = 8'd3;
    r0 = rd_reqs;
    rd_hold = 1;
    measure_fetch_latency("R4 retrigger does not restart delay", 1);
    for (int i = 0; i < 100 && rd_reqs == r0; i++) @(negedge clk);
    pulse_fetch(); idle(20);
    chk("R4 trigger in flight ignored", rd_reqs - r0, 1);
    chk("R10 pointer reset address", rd_alog[r0 % 16], 32'h2000);
    chk("R2 count after reset", rd_clog[r0 % 16], 3);
    rd_hold = 0;
    wait_rd(rd_dones + 1);
    chk("R4 still one request", rd_reqs - r0, 1);
    consume("R5 new ring", 0, 3, 4);
    chk("R12 request held until accept", hold_bad, 0);
    chk("R9 pulses one cycle", cmpl_multi, 0);
    ack_lag = 0;
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    t_reset();
    t_basic();
    t_limits();
    t_mask();
    t_clip();
    t_inflight_wb();
    t_reconfig();
    idle(5);
    summary();
  end
endmodule